// File: doc/BRIEF.md
# Dual-Channel Transfer Interrupt Status Unit

This block gathers single-cycle event pulses from two transfer channels of a SPI master into one interrupt register set. Each channel reports five kinds of event: command completion, receive overrun, transmit underrun, poll timeout and invalid control. Every event latches into a sticky raw status bit that software clears by writing ones. A mask register selects which pending bits may raise the interrupt. A read-only view shows raw status qualified by the mask, and one level-sensitive output requests service whenever that view is non-zero. When the line is shared, a handler can read the qualified view and treat zero as "not mine".

Software reaches the unit through a plain register port: address, write strobe, write data and combinational read data. A write takes effect at the clock edge on which the strobe is high. Read data follows the address in the same cycle. No data stream passes through the block, so the port has no valid/ready handshake and never applies back-pressure. The event inputs are plain pulses: one clock high per event, with no acknowledge.

Top module: `ppspi_irq_unit`

## Requirements
- R1: After reset, raw status, the mask and the qualified view all read as zero, and `irq_o` is low.
- R2: An event pulse on input index `c*5+k` (channel `c` in 0..1; `k` = 0 done, 1 rx overrun, 2 tx underrun, 3 poll timeout, 4 invalid control) sets raw status bit `c*8+k` at that clock edge. The bit stays set until it is cleared.
- R3: A write to offset 0x08 clears each defined raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 keep their value.
- R4: If an event and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: The mask register at offset 0x10 stores and reads back all 32 written bits, including reserved bits 31:24. Writing it never changes raw status.
- R6: Offset 0x0C reads as raw status AND mask.
- R7: `irq_o` is high exactly when the value at offset 0x0C is non-zero. It follows changes to the registers without extra delay.
- R8: Raw status bits outside 4:0 and 12:8 always read as zero. Writes to 0x0C or to any unmapped offset change no state. Unmapped offsets read as zero.
- R9: A write of 0xFF001F1F to offset 0x08 with no event in that cycle leaves raw status at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 10 | Event pulses, index channel*5 + event kind |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check on every clock the per-bit register rules: an event sets its bit, a clearing write without a competing event drops it, the set wins a collision, an untouched bit holds, the mask loads only on its own write, reserved raw bits stay zero, and the interrupt matches the qualified state. The bench's scenarios cover what shows only at the read port: the offset decode of the three views, zero reads from unmapped offsets, and long mixed runs of events, masks and clears that leave each register in the state the bench computes for it.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [7:0] OFS_RAW    = 8'h08;
  localparam logic [7:0] OFS_QUAL   = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;

  function automatic logic [DW-1:0] defined_bits(int unsigned nch, int unsigned nev,
                                                 int unsigned stride);
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < int'(nch); c++)
      for (int k = 0; k < int'(nev); k++)
        m[c*stride+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ppirq_status_bank.sv
module ppirq_status_bank #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned NEV    = 5,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*NEV-1:0] set_i,
  input  logic [NCH*NEV-1:0] clr_i,
  output logic [DW-1:0]     raw_o
);
  localparam int unsigned NB = NCH * NEV;

  logic [NB-1:0] st_q;

  // one sticky cell per defined event; set has priority over clear
  for (genvar j = 0; j < NB; j++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_q[j] <= 1'b0;
      else if (set_i[j])  st_q[j] <= 1'b1;
      else if (clr_i[j])  st_q[j] <= 1'b0;
    end
  end

  always_comb begin
    raw_o = '0;
    for (int c = 0; c < int'(NCH); c++)
      for (int k = 0; k < int'(NEV); k++)
        raw_o[c*STRIDE+k] = st_q[c*NEV+k];
  end
endmodule

// File: rtl/ppirq_mask_reg.sv
module ppirq_mask_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ppirq_read_mux.sv
module ppirq_read_mux
  import ppirq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] qual_o,
  output logic [DW-1:0] rdata_o
);
  assign qual_o = raw_i & mask_i;

  always_comb begin
    unique case (addr_i)
      OFS_RAW:  rdata_o = raw_i;
      OFS_QUAL: rdata_o = qual_o;
      OFS_MASK: rdata_o = mask_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ppspi_irq_unit.sv
module ppspi_irq_unit
  import ppirq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned NEV    = 5,
  parameter int unsigned STRIDE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NCH*NEV-1:0]   evt_i,
  output logic                 irq_o
);
  localparam int unsigned NB = NCH * NEV;

  logic          wr_raw, wr_mask;
  logic [NB-1:0] clr_w;
  logic [31:0]   raw_w, mask_w, qual_w;

  assign wr_raw  = reg_we && (reg_addr == OFS_RAW);
  assign wr_mask = reg_we && (reg_addr == OFS_MASK);

  // gather write-one-to-clear bits from their strided positions
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar k = 0; k < NEV; k++) begin : g_ev
      assign clr_w[c*NEV+k] = wr_raw & reg_wdata[c*STRIDE+k];
    end
  end

  ppirq_status_bank #(.NCH(NCH), .NEV(NEV), .STRIDE(STRIDE), .DW(32)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_w), .raw_o(raw_w)
  );

  ppirq_mask_reg #(.DW(32)) u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(wr_mask), .d_i(reg_wdata), .q_o(mask_w)
  );

  ppirq_read_mux #(.DW(32)) u_rd (
    .addr_i(reg_addr), .raw_i(raw_w), .mask_i(mask_w),
    .qual_o(qual_w), .rdata_o(reg_rdata)
  );

  assign irq_o = |qual_w;
endmodule

// File: rtl/ppirq_checker.sv
module ppirq_checker
  import ppirq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned NEV    = 5,
  parameter int unsigned STRIDE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         reg_addr,
  input logic               reg_we,
  input logic [31:0]        reg_wdata,
  input logic [NCH*NEV-1:0] evt_i,
  input logic [31:0]        raw,
  input logic [31:0]        mask,
  input logic               irq_o
);
  localparam logic [31:0] DEF = defined_bits(NCH, NEV, STRIDE);

  logic wr_raw, wr_mask;
  assign wr_raw  = reg_we && (reg_addr == OFS_RAW);
  assign wr_mask = reg_we && (reg_addr == OFS_MASK);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    for (genvar k = 0; k < NEV; k++) begin : g_k
      localparam int unsigned J = c*NEV + k;
      localparam int unsigned P = c*STRIDE + k;

      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[J] |=> raw[P]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && reg_wdata[P] && !evt_i[J]) |=> !raw[P]);
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[J] && !(wr_raw && reg_wdata[P])) |=> $stable(raw[P]));
      p_setwins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && reg_wdata[P] && evt_i[J]) |=> raw[P]);
    end
  end

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(reg_wdata)));
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask));
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((raw & mask) != 32'h0));
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & ~DEF) == 32'h0);
endmodule

bind ppspi_irq_unit ppirq_checker #(.NCH(NCH), .NEV(NEV), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .evt_i(evt_i), .raw(raw_w), .mask(mask_w), .irq_o(irq_o)
);

// File: tb/ppspi_irq_unit_bench.sv
`timescale 1ns/1ps
module ppspi_irq_unit_bench;
  localparam int NCH = 2, NEV = 5, STRIDE = 8;
  localparam logic [7:0] A_RAW = 8'h08, A_QUAL = 8'h0C, A_MASK = 8'h10;
  localparam logic [31:0] DEFB = 32'h0000_1F1F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH*NEV-1:0] evt_i = '0;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_raw = '0, m_mask = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ppspi_irq_unit #(.NCH(NCH), .NEV(NEV), .STRIDE(STRIDE)) u_ppspi_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] evt_to_bits(logic [NCH*NEV-1:0] e);
    logic [31:0] b = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NEV; k++)
        b[c*STRIDE+k] = e[c*NEV+k];
    return b;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // one cycle of stimulus; model updated per R2, R3, R4, R5, R8
  task automatic cyc(logic we, logic [7:0] a, logic [31:0] wd, logic [NCH*NEV-1:0] e);
    logic [31:0] clr;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; evt_i = e;
    clr = (we && a == A_RAW) ? (wd & DEFB) : 32'h0;
    m_raw = (m_raw & ~clr) | evt_to_bits(e);
    if (we && a == A_MASK) m_mask = wd;
    @(negedge clk);
    reg_we = 1'b0; evt_i = '0;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(A_RAW, v);  chk({tag, " R2 R3 raw"}, v, m_raw);
    rd(A_QUAL, v); chk({tag, " R6 qual"}, v, m_raw & m_mask);
    rd(A_MASK, v); chk({tag, " R5 mask"}, v, m_mask);
    chk({tag, " R7 irq"}, {31'b0, irq_o}, {31'b0, (m_raw & m_mask) != 0});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state (still in reset)
    check_all("R1 in-reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after-reset");

    // R2: each event kind on each channel
    cyc(1'b0, 8'h00, 32'h0, 10'b00000_10101);
    check_all("R2 ch0");
    cyc(1'b0, 8'h00, 32'h0, 10'b11010_00000);
    check_all("R2 ch1");
    // R7: unmask one bit
    cyc(1'b1, A_MASK, 32'h0000_0800, '0);
    check_all("R7 one-bit");
    // R5: masking to zero leaves raw intact
    cyc(1'b1, A_MASK, 32'h0, '0);
    check_all("R5 mask-zero");
    // R5: reserved mask bits read back
    cyc(1'b1, A_MASK, 32'hFF00_0001, '0);
    check_all("R5 rsvd");
    // R8: writes to qual and unmapped offsets ignored
    cyc(1'b1, A_QUAL, 32'hFFFF_FFFF, '0);
    cyc(1'b1, 8'h14, 32'hFFFF_FFFF, '0);
    cyc(1'b1, 8'h04, 32'hFFFF_FFFF, '0);
    check_all("R8 ignored-wr");
    rd(8'h04, v); chk("R8 unmapped read", v, 32'h0);
    // R3: partial clear
    cyc(1'b1, A_RAW, 32'h0000_0101, '0);
    check_all("R3 partial");
    // R4: set and clear collide on ch0 done
    cyc(1'b1, A_RAW, 32'h0000_0001, 10'b00000_00001);
    check_all("R4 collide");
    rd(A_RAW, v); chk("R4 bit0 kept", v & 32'h1, 32'h1);
    // R9: clear-all pattern
    cyc(1'b1, A_RAW, 32'hFF00_1F1F, '0);
    check_all("R9 clear-all");
    rd(A_RAW, v); chk("R9 raw zero", v, 32'h0);
    // R8: raw never shows bits outside defined fields
    cyc(1'b0, 8'h00, 32'h0, 10'h3FF);
    rd(A_RAW, v); chk("R8 raw rsvd", v & ~DEFB, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 5);
      case (sel)
        0, 1: a = A_RAW;
        2: a = A_MASK;
        3: a = A_QUAL;
        4: a = 8'h04;
        default: a = 8'h18;
      endcase
      cyc($urandom_range(0, 1) == 1, a, $urandom(),
          (($urandom_range(0, 3) == 0) ? 10'($urandom()) : '0));
      check_all("RND");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule